// File: doc/BRIEF.md
# Instruction Length Decoder and Operand Address Generator

This unit sits in the front end of a processor that uses variable-length instructions built from 16-bit halfwords. A fetch stage presents the first halfword and the two halfwords that may follow it. The top two bits of the opcode fix the instruction format and its length. From that, the unit works out how many storage operands the instruction names and forms each 24-bit operand address. Each address is the sum of a base register, an optional index register and a 12-bit displacement. Register values come from an external 16 x 32-bit register file through three combinational read selects.

The unit owns the instruction counter. An accepted instruction at an even counter value moves the counter forward by the instruction length in bytes. An odd counter value breaks halfword alignment, so the unit flags a specification fault and holds the counter where it is. A load strobe places a new value in the counter, for example a branch target.

All results are registered. They appear one cycle after the issue strobe and stay on the outputs until the next accepted issue.

Top module: `insn_addr_gen`

## Requirements
- R1: After reset the instruction counter is 0 and `res_valid` is 0.
- R2: The opcode prefix `hw0[15:14]` sets the format and length. Prefix 00 gives 2 bytes, 01 gives 4, 10 gives 4 and 11 gives 6. `res_fmt` equals the prefix.
- R3: For prefix 01 the address is base (designator `hw1[15:12]`) + index (designator `hw0[3:0]`) + displacement (`hw1[11:0]`). Base and index use the low 24 bits of the register, and the sum is taken modulo 2^24.
- R4: A base or index designator of 0 adds zero, whatever register 0 holds. A displacement of 0 is an ordinary value.
- R5: The operand count is 0 for prefix 00, 1 for prefixes 01 and 10, and 2 for prefix 11. Prefix 10 forms its address from `hw1` with no index term. Prefix 11 forms `res_ea1` from `hw1` and `res_ea2` from `hw2`. Unused address outputs are 0.
- R6: An issue at an even counter value advances the counter by the length in bytes, modulo 2^24. `res_next_addr` equals the new counter value.
- R7: An issue at an odd counter value sets `res_fault`, leaves the counter unchanged, reports `res_next_addr` equal to that counter, and gives an operand count of 0 with both addresses 0. The length and format are still reported.
- R8: `ic_load` writes `ic_load_addr` into the counter at the next edge. It takes priority over `issue_valid` in the same cycle, and that issue produces no result (`res_valid` stays 0).
- R9: `res_valid` is high for exactly the one cycle after an accepted issue. The other result outputs hold their values until the next accepted issue.
- R10: The read selects follow the current halfwords combinationally: `rf_sel_b1 = hw1[15:12]`, `rf_sel_x = hw0[3:0]` and `rf_sel_b2 = hw2[15:12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ic_load | input | 1 | Load the instruction counter |
| ic_load_addr | input | 24 | Value to load into the counter |
| issue_valid | input | 1 | Halfwords present an instruction to decode |
| hw0 | input | 16 | First halfword (opcode in bits 15:8) |
| hw1 | input | 16 | Second halfword |
| hw2 | input | 16 | Third halfword |
| rf_sel_b1 | output | 4 | Register select for the first base |
| rf_sel_x | output | 4 | Register select for the index |
| rf_sel_b2 | output | 4 | Register select for the second base |
| rf_data_b1 | input | 32 | Register value for the first base select |
| rf_data_x | input | 32 | Register value for the index select |
| rf_data_b2 | input | 32 | Register value for the second base select |
| res_valid | output | 1 | One-cycle pulse: a new result is on the outputs |
| res_fmt | output | 2 | Format class (opcode prefix) |
| res_len | output | 3 | Instruction length in bytes |
| res_ea_count | output | 2 | Number of operand addresses formed |
| res_ea1 | output | 24 | First operand address |
| res_ea2 | output | 24 | Second operand address |
| res_next_addr | output | 24 | Counter value after this instruction |
| res_fault | output | 1 | Halfword alignment fault |
| insn_counter | output | 24 | Current instruction counter |

## Verification
A corrupt counter shows on `insn_counter` at once, and on `res_next_addr` after the next issue. Because every issue adds an even length, one wrong step stays visible until the next load. A wrong format or length class shows in `res_len` and `res_ea_count` one cycle after the issue, and it also shifts every later counter value. A wrong address term, such as register 0 read in place of zero, a lost carry or an index used where none belongs, shows only in the address outputs of that single result. For this reason the bench compares every field of every result against an independent model, using random register contents and directed cases with zero designators and wrap-around.

// File: rtl/iag_pkg.sv
package iag_pkg;

    localparam int unsigned HALF_W   = 16;
    localparam int unsigned OPC_HI   = 15;
    localparam int unsigned DESIG_W  = 4;
    localparam int unsigned DISP_W   = 12;

    typedef enum logic [1:0] {
        FMT_REGREG = 2'b00,
        FMT_REGIDX = 2'b01,
        FMT_REGSTO = 2'b10,
        FMT_STOSTO = 2'b11
    } fmt_e;

endpackage

// File: rtl/iag_fmt_decode.sv
module iag_fmt_decode
    import iag_pkg::*;
(
    input  logic [1:0] prefix,
    output fmt_e       fmt,
    output logic [2:0] len_bytes,
    output logic [1:0] ea_count,
    output logic       uses_index
);

    always_comb begin
        fmt        = fmt_e'(prefix);
        len_bytes  = 3'd2;
        ea_count   = 2'd0;
        uses_index = 1'b0;
        unique case (fmt)
            FMT_REGREG: begin
                len_bytes = 3'd2;
                ea_count  = 2'd0;
            end
            FMT_REGIDX: begin
                len_bytes  = 3'd4;
                ea_count   = 2'd1;
                uses_index = 1'b1;
            end
            FMT_REGSTO: begin
                len_bytes = 3'd4;
                ea_count  = 2'd1;
            end
            FMT_STOSTO: begin
                len_bytes = 3'd6;
                ea_count  = 2'd2;
            end
            default: begin
                len_bytes = 3'd2;
                ea_count  = 2'd0;
            end
        endcase
    end

endmodule

// File: rtl/iag_ea_unit.sv
module iag_ea_unit #(
    parameter int unsigned AW    = 24,
    parameter int unsigned RW    = 32,
    parameter int unsigned SELW  = 4,
    parameter int unsigned DW    = 12
) (
    input  logic [SELW-1:0] base_sel,
    input  logic [RW-1:0]   base_val,
    input  logic            idx_en,
    input  logic [SELW-1:0] idx_sel,
    input  logic [RW-1:0]   idx_val,
    input  logic [DW-1:0]   disp,
    output logic [AW-1:0]   ea
);

    logic [AW-1:0] base_term;
    logic [AW-1:0] idx_term;

    always_comb begin
        base_term = (base_sel == '0) ? '0 : base_val[AW-1:0];
        idx_term  = (idx_en && (idx_sel != '0)) ? idx_val[AW-1:0] : '0;
        ea        = base_term + idx_term + AW'(disp);
    end

endmodule

// File: rtl/insn_addr_gen.sv
module insn_addr_gen
    import iag_pkg::*;
#(
    parameter int unsigned AW       = 24,
    parameter int unsigned RW       = 32,
    parameter int unsigned NREG     = 16,
    parameter logic [23:0] IC_RESET = 24'h000000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ic_load,
    input  logic [AW-1:0]            ic_load_addr,
    input  logic                     issue_valid,
    input  logic [15:0]              hw0,
    input  logic [15:0]              hw1,
    input  logic [15:0]              hw2,
    output logic [$clog2(NREG)-1:0]  rf_sel_b1,
    output logic [$clog2(NREG)-1:0]  rf_sel_x,
    output logic [$clog2(NREG)-1:0]  rf_sel_b2,
    input  logic [RW-1:0]            rf_data_b1,
    input  logic [RW-1:0]            rf_data_x,
    input  logic [RW-1:0]            rf_data_b2,
    output logic                     res_valid,
    output logic [1:0]               res_fmt,
    output logic [2:0]               res_len,
    output logic [1:0]               res_ea_count,
    output logic [AW-1:0]            res_ea1,
    output logic [AW-1:0]            res_ea2,
    output logic [AW-1:0]            res_next_addr,
    output logic                     res_fault,
    output logic [AW-1:0]            insn_counter
);

    localparam int unsigned SELW   = $clog2(NREG);
    localparam int unsigned NUM_EA = 2;

    typedef struct packed {
        logic [AW-1:0] ic;
        logic          valid;
        logic [1:0]    fmt;
        logic [2:0]    len;
        logic [1:0]    ea_cnt;
        logic [AW-1:0] ea1;
        logic [AW-1:0] ea2;
        logic [AW-1:0] next;
        logic          fault;
    } state_t;

    state_t st_d, st_q;

    // Field extraction
    fmt_e       dec_fmt;
    logic [2:0] dec_len;
    logic [1:0] dec_ea_cnt;
    logic       dec_uses_idx;

    iag_fmt_decode u_dec (
        .prefix     (hw0[OPC_HI -: 2]),
        .fmt        (dec_fmt),
        .len_bytes  (dec_len),
        .ea_count   (dec_ea_cnt),
        .uses_index (dec_uses_idx)
    );

    assign rf_sel_b1 = hw1[HALF_W-1 -: SELW];
    assign rf_sel_b2 = hw2[HALF_W-1 -: SELW];
    assign rf_sel_x  = hw0[SELW-1:0];

    logic [HALF_W-1:0] op_hw   [NUM_EA];
    logic [RW-1:0]     op_base [NUM_EA];
    logic [AW-1:0]     op_ea   [NUM_EA];

    assign op_hw[0]   = hw1;
    assign op_hw[1]   = hw2;
    assign op_base[0] = rf_data_b1;
    assign op_base[1] = rf_data_b2;

    generate
        for (genvar g = 0; g < NUM_EA; g++) begin : g_ea
            iag_ea_unit #(
                .AW   (AW),
                .RW   (RW),
                .SELW (SELW),
                .DW   (DISP_W)
            ) u_ea (
                .base_sel (op_hw[g][HALF_W-1 -: SELW]),
                .base_val (op_base[g]),
                .idx_en   ((g == 0) ? dec_uses_idx : 1'b0),
                .idx_sel  (rf_sel_x),
                .idx_val  (rf_data_x),
                .disp     (op_hw[g][DISP_W-1:0]),
                .ea       (op_ea[g])
            );
        end
    endgenerate

    // Next-state computation
    logic [AW-1:0] stepped;
    assign stepped = st_q.ic + AW'(dec_len);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (ic_load) begin
            st_d.ic = ic_load_addr;
        end else if (issue_valid) begin
            st_d.valid = 1'b1;
            st_d.fmt   = dec_fmt;
            st_d.len   = dec_len;
            if (st_q.ic[0]) begin
                st_d.fault  = 1'b1;
                st_d.ea_cnt = 2'd0;
                st_d.ea1    = '0;
                st_d.ea2    = '0;
                st_d.next   = st_q.ic;
            end else begin
                st_d.fault  = 1'b0;
                st_d.ea_cnt = dec_ea_cnt;
                st_d.ea1    = (dec_ea_cnt != 2'd0) ? op_ea[0] : '0;
                st_d.ea2    = (dec_ea_cnt == 2'd2) ? op_ea[1] : '0;
                st_d.next   = stepped;
                st_d.ic     = stepped;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ic     <= IC_RESET[AW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign insn_counter  = st_q.ic;
    assign res_valid     = st_q.valid;
    assign res_fmt       = st_q.fmt;
    assign res_len       = st_q.len;
    assign res_ea_count  = st_q.ea_cnt;
    assign res_ea1       = st_q.ea1;
    assign res_ea2       = st_q.ea2;
    assign res_next_addr = st_q.next;
    assign res_fault     = st_q.fault;

    // Assertions
    assert_len_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_len == 3'd2) == (res_fmt == 2'b00)) &&
                      ((res_len == 3'd6) == (res_fmt == 2'b11)));

    assert_regreg_no_ea_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fmt == 2'b00) |-> (res_ea_count == 2'd0 && res_ea1 == '0 && res_ea2 == '0));

    assert_zero_desig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !ic_load && !insn_counter[0] && hw0[15:14] == 2'b01 &&
         rf_sel_b1 == '0 && rf_sel_x == '0)
        |=> (res_ea1 == AW'($past(hw1[DISP_W-1:0]))));

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !ic_load && !insn_counter[0])
        |=> (insn_counter == $past(insn_counter) + AW'(res_len) && res_next_addr == insn_counter));

    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !ic_load && insn_counter[0])
        |=> ($stable(insn_counter) && res_fault && res_ea_count == 2'd0));

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ic_load |=> (insn_counter == $past(ic_load_addr) && !res_valid));

    assert_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ic_load |=> (insn_counter[0] == $past(insn_counter[0])));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && !ic_load) |=> !res_valid);

endmodule

// File: tb/insn_addr_gen_bench.sv
`timescale 1ns/1ps
module insn_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ic_load;
    logic [23:0] ic_load_addr;
    logic        issue_valid;
    logic [15:0] hw0, hw1, hw2;
    logic [3:0]  rf_sel_b1, rf_sel_x, rf_sel_b2;
    logic [31:0] rf_data_b1, rf_data_x, rf_data_b2;
    logic        res_valid;
    logic [1:0]  res_fmt;
    logic [2:0]  res_len;
    logic [1:0]  res_ea_count;
    logic [23:0] res_ea1, res_ea2, res_next_addr;
    logic        res_fault;
    logic [23:0] insn_counter;

    logic [31:0] regs [16];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [23:0] exp_ic;

    always #4 clk = ~clk;

    assign rf_data_b1 = regs[rf_sel_b1];
    assign rf_data_x  = regs[rf_sel_x];
    assign rf_data_b2 = regs[rf_sel_b2];

    insn_addr_gen u_insn_addr_gen (
        .clk(clk), .rst_n(rst_n), .ic_load(ic_load), .ic_load_addr(ic_load_addr),
        .issue_valid(issue_valid), .hw0(hw0), .hw1(hw1), .hw2(hw2),
        .rf_sel_b1(rf_sel_b1), .rf_sel_x(rf_sel_x), .rf_sel_b2(rf_sel_b2),
        .rf_data_b1(rf_data_b1), .rf_data_x(rf_data_x), .rf_data_b2(rf_data_b2),
        .res_valid(res_valid), .res_fmt(res_fmt), .res_len(res_len),
        .res_ea_count(res_ea_count), .res_ea1(res_ea1), .res_ea2(res_ea2),
        .res_next_addr(res_next_addr), .res_fault(res_fault), .insn_counter(insn_counter)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] m_len(input logic [1:0] p);
        return (p == 2'b00) ? 3'd2 : (p == 2'b11) ? 3'd6 : 3'd4;
    endfunction

    function automatic logic [1:0] m_cnt(input logic [1:0] p);
        return (p == 2'b00) ? 2'd0 : (p == 2'b11) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [23:0] m_ea(input logic [15:0] h, input logic [3:0] xs, input bit use_x);
        logic [23:0] b, x;
        b = (h[15:12] == 4'd0) ? 24'd0 : regs[h[15:12]][23:0];
        x = (use_x && xs != 4'd0) ? regs[xs][23:0] : 24'd0;
        return b + x + {12'd0, h[11:0]};
    endfunction

    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                        input bit iss, input bit ld, input logic [23:0] la);
        logic [1:0]  p;
        logic [23:0] e1, e2, nx;
        bit          flt;
        hw0 = a; hw1 = b; hw2 = c; issue_valid = iss; ic_load = ld; ic_load_addr = la;
        p = a[15:14];
        #1;
        chk("R10 sel_b1", {28'd0, rf_sel_b1}, {28'd0, b[15:12]});
        chk("R10 sel_x",  {28'd0, rf_sel_x},  {28'd0, a[3:0]});
        chk("R10 sel_b2", {28'd0, rf_sel_b2}, {28'd0, c[15:12]});
        flt = exp_ic[0];
        e1 = (flt || p == 2'b00) ? 24'd0 : m_ea(b, a[3:0], p == 2'b01);
        e2 = (flt || p != 2'b11) ? 24'd0 : m_ea(c, 4'd0, 1'b0);
        nx = flt ? exp_ic : exp_ic + {21'd0, m_len(p)};
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0; ic_load = 1'b0;
        if (ld) begin
            exp_ic = la;
            chk("R8 counter", {8'd0, insn_counter}, {8'd0, la});
            chk("R8 no result", {31'd0, res_valid}, 32'd0);
        end else if (iss) begin
            exp_ic = nx;
            chk("R9 valid", {31'd0, res_valid}, 32'd1);
            chk("R2 fmt", {30'd0, res_fmt}, {30'd0, p});
            chk("R2 len", {29'd0, res_len}, {29'd0, m_len(p)});
            chk("R7 fault", {31'd0, res_fault}, {31'd0, flt});
            chk("R5 count", {30'd0, res_ea_count}, flt ? 32'd0 : {30'd0, m_cnt(p)});
            chk("R3 ea1", {8'd0, res_ea1}, {8'd0, e1});
            chk("R5 ea2", {8'd0, res_ea2}, {8'd0, e2});
            chk("R6 next", {8'd0, res_next_addr}, {8'd0, nx});
            chk("R6 counter", {8'd0, insn_counter}, {8'd0, nx});
        end else begin
            chk("R9 idle", {31'd0, res_valid}, 32'd0);
            chk("R9 counter", {8'd0, insn_counter}, {8'd0, exp_ic});
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) regs[i] = $urandom;
        rst_n = 1'b0; ic_load = 0; ic_load_addr = 0; issue_valid = 0;
        hw0 = 0; hw1 = 0; hw2 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_ic = 24'd0;
        chk("R1 counter", {8'd0, insn_counter}, 32'd0);
        chk("R1 valid", {31'd0, res_valid}, 32'd0);

        // R2 R6: register form at 0
        step(16'h1a23, 16'h0000, 16'h0000, 1, 0, 0);
        // R4: zero base and index with nonzero register 0
        regs[0] = 32'h00ab_cdef;
        step(16'h5a30, 16'h0123, 16'h0000, 1, 0, 0);
        // R4: zero displacement
        step(16'h4105, 16'h3000, 16'h0000, 1, 0, 0);
        // R3: wrap-around of the 24-bit sum
        regs[7] = 32'h12ff_ffff; regs[9] = 32'h0000_0010;
        step(16'h4a09, 16'h7fff, 16'h0000, 1, 0, 0);
        // R5: register/storage form ignores index field
        step(16'h8a09, 16'h7004, 16'h0000, 1, 0, 0);
        // R5: storage-to-storage two addresses
        step(16'hd2ff, 16'h7010, 16'h9020, 1, 0, 0);
        // R9: idle cycle holds counter, no pulse
        step(16'h0000, 16'h0000, 16'h0000, 0, 0, 0);
        // R8: load odd, then R7 fault
        step(16'h0000, 16'h0000, 16'h0000, 0, 1, 24'h000101);
        step(16'hd2ff, 16'h7010, 16'h9020, 1, 0, 0);
        step(16'h4a09, 16'h7fff, 16'h0000, 1, 0, 0);
        // R8: load with simultaneous issue
        step(16'h4a09, 16'h7fff, 16'h0000, 1, 1, 24'hfffffc);
        // R6: counter wrap
        step(16'hd000, 16'h0000, 16'h0000, 1, 0, 0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) regs[r[7:4]] = $urandom;
            if (r[9:4] == 6'd0)
                step(16'($urandom), 16'($urandom), 16'($urandom), r[10], 1, 24'($urandom));
            else
                step(16'($urandom), 16'($urandom), 16'($urandom), r[11] | r[12], 0, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule